// File: doc/BRIEF.md
# DDR Refresh and Power-State Sequencer

This block sits on the controller side of a DDR SDRAM interface. It owns the clock-enable pin and a small command bus for auto-refresh and for the low-power commands: self-refresh entry and exit, and power-down entry and exit. It counts the average refresh interval. The interval is derived from the clock period, which is a parameter. The block also enforces the waits that each of these commands imposes on later traffic.

A front-end arbiter offers one command at a time with `req_valid` and a kind code. `req_ready` grants the command in the same cycle, and a neighbouring multiplexer then puts it on the bus. The grant is withheld while a refresh is being scheduled, while a low-power entry is being issued, while the device is not awake, or while a timer that applies to that kind of command is still running.

Low-power states are requested by level inputs. A request that rises while a timer is still running raises an error pulse. The request is then held over until the timers clear. During power-down, the block leaves the state by itself to refresh when the interval runs out, and goes back in if the request is still held.

Top module: `ddr_pwr_seq`

## Requirements
- R1: With nothing in the way, a refresh command (code 1 on `mem_cmd`) is issued every REFI_CYC = REFI_PS / CLK_PS cycles. The arbiter's grant is low in the cycle just before each refresh.
- R2: After a refresh seen in cycle c, kind 0 (activate) and kind 1 (mode-register-set) are not granted before cycle c + T_RFC and are granted from then on. Kind 2 (read) and kind 3 (other) are not held back by the refresh.
- R3: `bank_clr` is high for exactly the cycle in which a refresh is shown. No precharge command exists.
- R4: When `sr_req` is set while awake and idle, self-refresh entry (code 2) appears one cycle later with `clk_en_o` low. `clk_en_o` stays low until `sr_req` drops. Exit (code 3) then appears one cycle later with `clk_en_o` high.
- R5: After a self-refresh exit in cycle s, kinds 0, 1 and 3 are granted from cycle s + T_SNR and not before.
- R6: After a self-refresh exit in cycle s, kind 2 is granted from cycle s + T_SRD and not before.
- R7: The first refresh after a self-refresh exit in cycle s comes in cycle s + REFI_CYC.
- R8: Power-down entry (code 4) appears one cycle after `pd_req` is set, with `clk_en_o` low. Exit (code 5, `clk_en_o` high) appears one cycle after `pd_req` drops. Grants resume T_PDEX cycles after the exit.
- R9: If the refresh interval runs out during power-down, the block exits, issues a refresh after the wake-up wait, and re-enters power-down T_RFC + 1 cycles after that refresh if `pd_req` is still held.
- R10: A refresh that falls due takes priority over a valid arbiter request, which is stalled (`req_ready` low) in that cycle.
- R11: A rising `pd_req` or `sr_req` while a refresh or exit timer runs gives a one-cycle `lp_err` pulse in the next cycle and no entry. A held request (one that did not just rise) raises no error and enters once the timers clear.
- R12: After reset, `clk_en_o` is high, `mem_cmd` is 0 (no operation), `lp_err` is low and every kind is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Arbiter has a command pending |
| req_kind | input | 2 | 0 activate, 1 mode-register-set, 2 read, 3 other |
| req_ready | output | 1 | Pending command granted this cycle |
| sr_req | input | 1 | Hold high to stay in self-refresh |
| pd_req | input | 1 | Hold high to stay in power-down |
| clk_en_o | output | 1 | Clock-enable to the memory |
| mem_cmd | output | 3 | Sequencer command code, registered |
| bank_clr | output | 1 | All banks become idle (refresh issued) |
| lp_err | output | 1 | Low-power request rejected |

## Verification
The sequencer's commands are registered, so each appears one cycle after the input or counter state that decides it. Examples are entry and exit one cycle after the request level changes, and an error one cycle after a rejected rise. Grants are combinational. A grant that depends on a timer loaded by a command in cycle c opens exactly T cycles later, in cycle c + T. The bench drives inputs just after the falling edge and samples one step later. It counts cycles from each observed command and checks the grant in the last blocked cycle and in the first open cycle, the refresh in its exact cycle, and the clock-enable level throughout each low-power stay.

// File: rtl/ddr_pwr_pkg.sv
package ddr_pwr_pkg;

    typedef enum logic [2:0] {
        C_NOP = 3'd0,
        C_REF = 3'd1,
        C_SRE = 3'd2,
        C_SRX = 3'd3,
        C_PDE = 3'd4,
        C_PDX = 3'd5
    } mcmd_e;

    typedef enum logic [1:0] {
        K_ACT   = 2'd0,
        K_MRS   = 2'd1,
        K_READ  = 2'd2,
        K_OTHER = 2'd3
    } rkind_e;

    typedef enum logic [1:0] {
        S_RUN  = 2'd0,
        S_SR   = 2'd1,
        S_PD   = 2'd2,
        S_WAKE = 2'd3
    } pstate_e;

    localparam int TI_REFI = 0;
    localparam int TI_RFC  = 1;
    localparam int TI_SNR  = 2;
    localparam int TI_SRD  = 3;
    localparam int TI_WAKE = 4;
    localparam int NT      = 5;

endpackage

// File: rtl/ddr_cdown.sv
module ddr_cdown #(
    parameter int CW      = 8,
    parameter int RST_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          en,
    output logic [CW-1:0] cnt
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (en && (cnt_q != '0)) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CW'(RST_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/ddr_pwr_seq.sv
module ddr_pwr_seq
    import ddr_pwr_pkg::*;
#(
    parameter int CLK_PS  = 5000,
    parameter int REFI_PS = 7_800_000,
    parameter int T_RFC   = 14,
    parameter int T_SNR   = 15,
    parameter int T_SRD   = 200,
    parameter int T_PDEX  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_kind,
    output logic       req_ready,
    input  logic       sr_req,
    input  logic       pd_req,
    output logic       clk_en_o,
    output logic [2:0] mem_cmd,
    output logic       bank_clr,
    output logic       lp_err
);

    localparam int REFI_CYC = REFI_PS / CLK_PS;
    localparam int MAX_A    = (REFI_CYC > T_SRD) ? REFI_CYC : T_SRD;
    localparam int MAX_B    = (T_RFC > T_SNR) ? T_RFC : T_SNR;
    localparam int MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAXV     = (MAX_C > T_PDEX) ? MAX_C : T_PDEX;
    localparam int CW       = $clog2(MAXV + 1);

    typedef struct packed {
        pstate_e st;
        mcmd_e   cmd;
        logic    cke;
        logic    err;
        logic    bclr;
        logic    sr_h;
        logic    pd_h;
    } seq_s;

    seq_s r_q, r_d;

    logic [NT-1:0] ld, en, zr;
    logic [CW-1:0] lv  [NT];
    logic [CW-1:0] cnt [NT];

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        ddr_cdown #(
            .CW      (CW),
            .RST_VAL ((i == TI_REFI) ? REFI_CYC - 1 : 0)
        ) u_t (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ld[i]),
            .load_val (lv[i]),
            .en       (en[i]),
            .cnt      (cnt[i])
        );
        assign zr[i] = (cnt[i] == '0);
    end

    logic due, busy, rise, kind_ok;

    always_comb begin
        due  = zr[TI_REFI];
        busy = !zr[TI_RFC] || !zr[TI_SNR] || !zr[TI_SRD];
        rise = (sr_req && !r_q.sr_h) || (pd_req && !r_q.pd_h);
        case (rkind_e'(req_kind))
            K_ACT, K_MRS: kind_ok = zr[TI_RFC] && zr[TI_SNR];
            K_READ:       kind_ok = zr[TI_SRD];
            default:      kind_ok = zr[TI_SNR];
        endcase
    end

    always_comb begin
        r_d      = r_q;
        r_d.cmd  = C_NOP;
        r_d.err  = 1'b0;
        r_d.bclr = 1'b0;
        r_d.sr_h = sr_req;
        r_d.pd_h = pd_req;
        ld       = '0;
        for (int i = 0; i < NT; i++) begin
            lv[i] = '0;
        end
        en          = '1;
        en[TI_REFI] = (r_q.st != S_SR);
        req_ready   = 1'b0;

        case (r_q.st)
            S_RUN: begin
                if (rise && busy) begin
                    r_d.err = 1'b1;
                end
                if (due) begin
                    if (zr[TI_RFC] && zr[TI_SNR]) begin
                        r_d.cmd      = C_REF;
                        r_d.bclr     = 1'b1;
                        ld[TI_REFI]  = 1'b1;
                        lv[TI_REFI]  = CW'(REFI_CYC - 1);
                        ld[TI_RFC]   = 1'b1;
                        lv[TI_RFC]   = CW'(T_RFC);
                    end
                end else if (sr_req && !busy) begin
                    r_d.cmd = C_SRE;
                    r_d.cke = 1'b0;
                    r_d.st  = S_SR;
                end else if (pd_req && !busy) begin
                    r_d.cmd = C_PDE;
                    r_d.cke = 1'b0;
                    r_d.st  = S_PD;
                end else begin
                    req_ready = kind_ok;
                end
            end
            S_SR: begin
                if (!sr_req) begin
                    r_d.cmd     = C_SRX;
                    r_d.cke     = 1'b1;
                    r_d.st      = S_RUN;
                    ld[TI_SNR]  = 1'b1;
                    lv[TI_SNR]  = CW'(T_SNR);
                    ld[TI_SRD]  = 1'b1;
                    lv[TI_SRD]  = CW'(T_SRD);
                    ld[TI_REFI] = 1'b1;
                    lv[TI_REFI] = CW'(REFI_CYC - 1);
                end
            end
            S_PD: begin
                if (!pd_req || due) begin
                    r_d.cmd     = C_PDX;
                    r_d.cke     = 1'b1;
                    r_d.st      = S_WAKE;
                    ld[TI_WAKE] = 1'b1;
                    lv[TI_WAKE] = CW'(T_PDEX);
                end
            end
            default: begin
                if (cnt[TI_WAKE] <= CW'(1)) begin
                    r_d.st = S_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st   <= S_RUN;
            r_q.cmd  <= C_NOP;
            r_q.cke  <= 1'b1;
            r_q.err  <= 1'b0;
            r_q.bclr <= 1'b0;
            r_q.sr_h <= 1'b0;
            r_q.pd_h <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign clk_en_o = r_q.cke;
    assign mem_cmd  = r_q.cmd;
    assign bank_clr = r_q.bclr;
    assign lp_err   = r_q.err;

    AST_SR_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_SR) |-> !clk_en_o); // R4
    AST_PD_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_PD) |-> !clk_en_o); // R8
    AST_RFC_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == C_REF && req_kind inside {K_ACT, K_MRS}) |-> !req_ready); // R2
    AST_SRX_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cmd == C_SRX) |-> !req_ready); // R5
    AST_BCLR_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        bank_clr |-> clk_en_o); // R3
    AST_ERR_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        lp_err |-> !(mem_cmd inside {C_SRE, C_PDE})); // R11
    AST_GRANT_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> clk_en_o); // R12

endmodule

// File: tb/sim_ddr_pwr_seq.sv
module sim_ddr_pwr_seq;

    localparam int CLK_PS  = 20000;
    localparam int REFI_PS = 7_800_000;
    localparam int REFI    = REFI_PS / CLK_PS;
    localparam int T_RFC   = 14;
    localparam int T_SNR   = 15;
    localparam int T_SRD   = 200;
    localparam int T_PDEX  = 1;
    localparam int WD_LIM  = 20000;

    localparam logic [2:0] NOP = 3'd0, REF = 3'd1, SRE = 3'd2, SRX = 3'd3,
                           PDE = 3'd4, PDX = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic req_ready;
    logic sr_req = 1'b0;
    logic pd_req = 1'b0;
    logic clk_en_o;
    logic [2:0] mem_cmd;
    logic bank_clr;
    logic lp_err;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int off = 0;

    always #10ns clk = ~clk;

    ddr_pwr_seq #(
        .CLK_PS(CLK_PS), .REFI_PS(REFI_PS), .T_RFC(T_RFC),
        .T_SNR(T_SNR), .T_SRD(T_SRD), .T_PDEX(T_PDEX)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_ready(req_ready), .sr_req(sr_req), .pd_req(pd_req),
        .clk_en_o(clk_en_o), .mem_cmd(mem_cmd), .bank_clr(bank_clr),
        .lp_err(lp_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIM) begin
            fails = fails + 1;
            tests = tests + 1;
            $display("FAIL watchdog: act %0d cycles exp below %0d", cyc, WD_LIM);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
        off = off + n;
    endtask

    task automatic go_to(input int target);
        step(target - off);
    endtask

    task automatic setk(input logic [1:0] k);
        req_kind = k;
        #1;
    endtask

    task automatic find_cmd(input logic [2:0] c, input int lim);
        int n = 0;
        while (mem_cmd != c && n < lim) begin
            step(1);
            n++;
        end
        off = 0;
    endtask

    task automatic t_reset();
        req_valid = 1'b1;
        chk("R12", "clk_en", int'(clk_en_o), 1);
        chk("R12", "cmd", int'(mem_cmd), int'(NOP));
        chk("R12", "err", int'(lp_err), 0);
        for (int k = 0; k < 4; k++) begin
            setk(2'(k));
            chk("R12", "ready per kind", int'(req_ready), 1);
        end
    endtask

    task automatic t_refresh();
        find_cmd(REF, 2 * REFI);
        chk("R1", "first refresh seen", int'(mem_cmd), int'(REF));
        setk(2'd3);
        go_to(REFI - 2);
        chk("R10", "ready before due", int'(req_ready), 1);
        go_to(REFI - 1);
        chk("R10", "ready stalled when due", int'(req_ready), 0);
        go_to(REFI);
        off = 0;
        chk("R1", "refresh period", int'(mem_cmd), int'(REF));
        chk("R3", "bank_clr with refresh", int'(bank_clr), 1);
        setk(2'd2);
        chk("R2", "read during tRFC", int'(req_ready), 1);
        setk(2'd0);
        chk("R2", "act at refresh", int'(req_ready), 0);
        setk(2'd1);
        chk("R2", "mrs at refresh", int'(req_ready), 0);
        step(1);
        chk("R3", "bank_clr one cycle", int'(bank_clr), 0);
        setk(2'd0);
        go_to(T_RFC - 1);
        chk("R2", "act last blocked", int'(req_ready), 0);
        go_to(T_RFC);
        chk("R2", "act open", int'(req_ready), 1);
    endtask

    task automatic t_selfref();
        int low_bad = 0;
        sr_req = 1'b1;
        step(1);
        chk("R4", "entry cmd", int'(mem_cmd), int'(SRE));
        chk("R4", "clk_en low", int'(clk_en_o), 0);
        for (int k = 0; k < 50; k++) begin
            step(1);
            if (clk_en_o !== 1'b0) low_bad++;
        end
        chk("R4", "clk_en low held", low_bad, 0);
        sr_req = 1'b0;
        step(1);
        off = 0;
        chk("R4", "exit cmd", int'(mem_cmd), int'(SRX));
        chk("R4", "clk_en high", int'(clk_en_o), 1);
        setk(2'd3);
        go_to(T_SNR - 1);
        chk("R5", "other last blocked", int'(req_ready), 0);
        go_to(T_SNR);
        chk("R5", "other open", int'(req_ready), 1);
        setk(2'd0);
        chk("R5", "act open", int'(req_ready), 1);
        setk(2'd2);
        chk("R6", "read blocked", int'(req_ready), 0);
        go_to(20);
        pd_req = 1'b1;
        step(1);
        chk("R11", "err pulse", int'(lp_err), 1);
        chk("R11", "no entry", int'(mem_cmd), int'(NOP));
        step(1);
        chk("R11", "err one cycle", int'(lp_err), 0);
        go_to(25);
        pd_req = 1'b0;
        go_to(T_SRD - 1);
        chk("R6", "read last blocked", int'(req_ready), 0);
        go_to(T_SRD);
        chk("R6", "read open", int'(req_ready), 1);
        go_to(205);
        pd_req = 1'b1;
        step(1);
        chk("R8", "pd entry", int'(mem_cmd), int'(PDE));
        chk("R8", "clk_en low", int'(clk_en_o), 0);
        go_to(215);
        pd_req = 1'b0;
        setk(2'd3);
        step(1);
        chk("R8", "pd exit", int'(mem_cmd), int'(PDX));
        chk("R8", "clk_en high", int'(clk_en_o), 1);
        chk("R8", "no grant in exit", int'(req_ready), 0);
        go_to(216 + T_PDEX);
        chk("R8", "grant after wake", int'(req_ready), 1);
        go_to(REFI - 1);
        chk("R7", "no refresh early", int'(mem_cmd), int'(NOP));
        go_to(REFI);
        chk("R7", "refresh after exit", int'(mem_cmd), int'(REF));
    endtask

    task automatic t_pd_refresh();
        int errs = 0;
        off = 0;
        req_valid = 1'b0;
        go_to(T_RFC);
        pd_req = 1'b1;
        step(1);
        chk("R9", "pd entry", int'(mem_cmd), int'(PDE));
        go_to(REFI - 1);
        chk("R9", "still down", int'(clk_en_o), 0);
        go_to(REFI);
        chk("R9", "exit for refresh", int'(mem_cmd), int'(PDX));
        go_to(REFI + 1 + T_PDEX);
        chk("R9", "refresh after wake", int'(mem_cmd), int'(REF));
        off = 0;
        while (off < T_RFC) begin
            step(1);
            if (lp_err !== 1'b0) errs++;
        end
        chk("R9", "awake during tRFC", int'(clk_en_o), 1);
        step(1);
        chk("R9", "re-entry", int'(mem_cmd), int'(PDE));
        chk("R11", "held request no err", errs + int'(lp_err), 0);
        pd_req = 1'b0;
        step(1);
        chk("R8", "final exit", int'(mem_cmd), int'(PDX));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_refresh();
        t_selfref();
        t_pd_refresh();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule